// File: doc/BRIEF.md
# Slave-FIFO Loopback Master

This block is the synchronous master for the slave-FIFO port of an external USB peripheral controller. It runs entirely on the interface clock. The controller holds an OUT endpoint FIFO that fills with host data and an IN endpoint FIFO that drains back to the host. The block moves 16-bit words from the OUT FIFO into a local buffer. When a batch is collected, it writes the words back, in order, into the IN FIFO. A 512-byte USB packet therefore crosses the port as 256 words.

At startup the block raises a configuration-done output as soon as it leaves reset. This tells the controller that it can switch its interface clock source. The block issues no strobe until the controller answers with a sync level. Before each phase, the endpoint address is switched while the port is idle. Only the write phase drives the data bus. After a write phase that ends part-way through a packet, a packet-end pulse commits the short IN packet.

Top module: `usb_fifo_loopback`

## Requirements
- R1: While reset is held, the block keeps rd_n, oe_n, wr_n and pktend_n high, keeps bus_drive low, drives ep_sel to OUT_EP and holds cfg_done low. From the first clock edge after reset is released, cfg_done is high and stays high.
- R2: No strobe (rd_n, oe_n, wr_n, pktend_n) goes low until sync_in has been seen high at a clock edge after cfg_done is set. Once the block has started, later levels on sync_in have no effect.
- R3: In the read phase, ep_sel equals OUT_EP (default 2'b00). oe_n and rd_n are low together exactly when out_avail is high (OUT FIFO holds data) and the local buffer is not full. The word on bus_in is stored at every clock edge where rd_n is low.
- R4: wr_n is low only when three conditions hold together: the block is in the write phase, in_room is high (IN FIFO not full), and the local buffer is not empty. bus_out shows the oldest buffered word, and the buffer advances by one word at every clock edge where wr_n is low.
- R5: Every word taken from the OUT FIFO appears in the IN FIFO, unchanged and in the same order. This includes the first words after sync.
- R6: The local buffer holds DEPTH words (default 512). A read phase ends when the buffer is full, or when out_avail is low and at least one word is held. A write phase lasts until the buffer is empty.
- R7: ep_sel changes only when every strobe was high in the cycle before the change and is high in the cycle of the change. The IN FIFO address is IN_EP (default 2'b10).
- R8: bus_drive is high only in the write phase. It is never high in a cycle where oe_n or rd_n is low.
- R9: A write phase can end with a count of words written since the last packet boundary that is not a multiple of PKT_WORDS. In that case pktend_n goes low for exactly one cycle, with ep_sel = IN_EP and all other strobes high. Otherwise no pulse is issued.
- R10: While in_room is low, wr_n stays high. The write resumes when room returns, and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Start level from the controller |
| out_avail | input | 1 | OUT FIFO flag, high when data is present |
| in_room | input | 1 | IN FIFO flag, high when not full |
| bus_in | input | DATA_W | Data bus as driven by the controller |
| bus_out | output | DATA_W | Data bus value driven by the block |
| bus_drive | output | 1 | Output enable of the block's bus drivers |
| ep_sel | output | 2 | Endpoint FIFO address |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Controller output enable, active low |
| pktend_n | output | 1 | Packet-end strobe, active low |
| cfg_done | output | 1 | Configuration-done indication |

## Verification
The bench builds the block with DEPTH = 64 and PKT_WORDS = 16. The small buffer lets a 100-word burst hit the buffer-full exit within a few hundred cycles. The short packet lets bursts of 20, 16, 40 and 5 words both land on packet boundaries and miss them, so that pulses are both expected and forbidden. A 24-word limit on the modelled IN FIFO, with the host drain held off, brings the write-stall case within reach.

// File: rtl/usb_fifo_loopback.sv
module usb_fifo_loopback #(
  parameter int          DATA_W    = 16,
  parameter int          DEPTH     = 512,
  parameter int          PKT_WORDS = 256,
  parameter logic [1:0]  OUT_EP    = 2'b00,
  parameter logic [1:0]  IN_EP     = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              out_avail,
  input  logic              in_room,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_drive,
  output logic [1:0]        ep_sel,
  output logic              rd_n,
  output logic              wr_n,
  output logic              oe_n,
  output logic              pktend_n,
  output logic              cfg_done
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(PKT_WORDS) + 1;

  typedef enum logic [2:0] {
    S_WAIT, S_RD, S_RHOLD, S_WSET, S_WR, S_PKT, S_WHOLD, S_RSET
  } st_t;

  st_t               st, st_nxt;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IW-1:0]     head, tail;
  logic [CW-1:0]     cnt, cnt_nxt;
  logic [PW-1:0]     pk, pk_nxt;
  logic              rd_go, wr_go, buf_full, buf_empty, idle;

  assign buf_full  = (cnt == CW'(DEPTH));
  assign buf_empty = (cnt == '0);
  assign rd_go     = (st == S_RD) && out_avail && !buf_full;
  assign wr_go     = (st == S_WR) && in_room && !buf_empty;

  assign rd_n      = !rd_go;
  assign oe_n      = !rd_go;
  assign wr_n      = !wr_go;
  assign pktend_n  = (st != S_PKT);
  assign bus_drive = (st == S_WR);
  assign bus_out   = mem[head];
  assign ep_sel    = (st inside {S_WSET, S_WR, S_PKT, S_WHOLD}) ? IN_EP : OUT_EP;
  assign idle      = rd_n & oe_n & wr_n & pktend_n;

  assign cnt_nxt = cnt + CW'(rd_go) - CW'(wr_go);

  always_comb begin
    pk_nxt = pk;
    if (wr_go) pk_nxt = (pk == PW'(PKT_WORDS - 1)) ? '0 : pk + 1'b1;
  end

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_WAIT:  if (sync_in && cfg_done) st_nxt = S_RD;
      S_RD:    if (cnt_nxt == CW'(DEPTH) || (!out_avail && !buf_empty)) st_nxt = S_RHOLD;
      S_RHOLD: st_nxt = S_WSET;
      S_WSET:  st_nxt = S_WR;
      S_WR:    if (cnt_nxt == '0) st_nxt = (pk_nxt != '0) ? S_PKT : S_WHOLD;
      S_PKT:   st_nxt = S_WHOLD;
      S_WHOLD: st_nxt = S_RSET;
      S_RSET:  st_nxt = S_RD;
      default: st_nxt = S_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_WAIT;
      cnt      <= '0;
      head     <= '0;
      tail     <= '0;
      pk       <= '0;
      cfg_done <= 1'b0;
    end else begin
      st       <= st_nxt;
      cnt      <= cnt_nxt;
      cfg_done <= 1'b1;
      if (rd_go) tail <= tail + 1'b1;
      if (wr_go) head <= head + 1'b1;
      pk <= (st == S_PKT) ? '0 : pk_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_go) mem[tail] <= bus_in;
  end

  a_r1_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);
  a_r2_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> idle);
  a_r3_read_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (out_avail && !oe_n && ep_sel == OUT_EP && cnt < CW'(DEPTH)));
  a_r4_write_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (in_room && bus_drive && ep_sel == IN_EP));
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r7_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ep_sel) |-> (idle && $past(idle)));
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (oe_n && rd_n));
  a_r9_pkt_single: assert property (@(posedge clk) disable iff (!rst_n)
    !pktend_n |=> pktend_n);
endmodule

// File: tb/tb_usb_fifo_loopback.sv
`timescale 1ns/1ps
module tb_usb_fifo_loopback;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0;
  logic out_avail = 1'b0, in_room = 1'b1;
  logic [DW-1:0] bus_in = '0, bus_out;
  logic bus_drive, rd_n, wr_n, oe_n, pktend_n, cfg_done;
  logic [1:0] ep_sel;

  usb_fifo_loopback #(.DATA_W(DW), .DEPTH(64), .PKT_WORDS(16)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .out_avail(out_avail),
    .in_room(in_room), .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive),
    .ep_sel(ep_sel), .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n),
    .pktend_n(pktend_n), .cfg_done(cfg_done));

  always #2 clk = ~clk;

  logic [DW-1:0] out_q[$], in_q[$], exp_q[$];
  int checks = 0, fails = 0;
  int in_cap = 1000;
  bit drain_en = 1'b1, started = 1'b0;
  int pre_err = 0, under_err = 0, over_err = 0, wempty_err = 0, oe_err = 0;
  int bus_err = 0, addr_err = 0, pkt_cnt = 0, pend = 0, run = 0, max_run = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // controller model: acts on strobes seen during the previous cycle, then updates flags
  initial begin
    logic s_rd, s_wr, s_pkt, s_oe, s_drv, p_idle, idle_now;
    logic [1:0] s_sel, p_sel;
    logic [DW-1:0] s_do;
    s_rd = 1; s_wr = 1; s_pkt = 1; s_oe = 1; s_drv = 0; p_idle = 1; p_sel = 2'b00; s_do = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!s_rd) begin
          if (out_q.size() == 0) under_err++; else void'(out_q.pop_front());
          pend++; run++;
          if (run > max_run) max_run = run;
        end
        if (!s_wr) begin
          if (in_q.size() >= in_cap) over_err++;
          if (pend == 0) wempty_err++; else pend--;
          in_q.push_back(s_do);
          run = 0;
        end
        if (!s_pkt) pkt_cnt++;
        if (drain_en && in_q.size() > 0) begin
          logic [DW-1:0] got;
          got = in_q.pop_front();
          if (exp_q.size() == 0) chk(1'b0, "R5 extra word", int'(got), -1);
          else begin
            logic [DW-1:0] want;
            want = exp_q.pop_front();
            chk(got == want, "R5 loopback word", int'(got), int'(want));
          end
        end
      end
      out_avail = (out_q.size() != 0);
      in_room   = (in_q.size() < in_cap);
      bus_in    = (out_q.size() != 0) ? out_q[0] : 16'hDEAD;
      #1;
      s_rd = rd_n; s_wr = wr_n; s_pkt = pktend_n; s_oe = oe_n; s_drv = bus_drive;
      s_sel = ep_sel; s_do = bus_out;
      if (rst_n) begin
        idle_now = s_rd & s_wr & s_pkt & s_oe;
        if (!started && !idle_now) pre_err++;
        if (s_oe != s_rd) oe_err++;
        if (s_drv && (!s_oe || !s_rd)) bus_err++;
        if (!s_wr && !in_room) over_err++;
        if (s_sel != p_sel && !(idle_now && p_idle)) addr_err++;
        if (!s_wr && s_sel != 2'b10) addr_err++;
        if (!s_rd && s_sel != 2'b00) addr_err++;
        if (!s_pkt && (s_sel != 2'b10 || !s_wr)) addr_err++;
        p_idle = idle_now; p_sel = s_sel;
      end
    end
  end

  task automatic send(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      out_q.push_back(base + DW'(i));
      exp_q.push_back(base + DW'(i));
    end
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && (exp_q.size() != 0 || in_q.size() != 0); i++) @(posedge clk);
    repeat (12) @(posedge clk);
    chk(exp_q.size() == 0, "R5 all words returned", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    chk(cfg_done == 1'b0, "R1 done low in reset", cfg_done, 0);
    chk({rd_n, oe_n, wr_n, pktend_n} == 4'hF, "R1 strobes idle in reset", {rd_n, oe_n, wr_n, pktend_n}, 15);
    chk(bus_drive == 1'b0, "R1 bus released in reset", bus_drive, 0);
    chk(ep_sel == 2'b00, "R1 OUT address in reset", ep_sel, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #2;
    chk(cfg_done == 1'b1, "R1 done after reset", cfg_done, 1);

    // R2: data waits in the OUT FIFO until sync
    send(20, 16'h1000);
    repeat (30) @(posedge clk);
    chk(out_q.size() == 20, "R2 nothing read before sync", out_q.size(), 20);
    chk(pre_err == 0, "R2 no strobe before sync", pre_err, 0);
    @(posedge clk); #1 started = 1'b1; sync_in = 1'b1;
    wait_drain();
    chk(pkt_cnt == 1, "R9 short packet committed", pkt_cnt, 1);

    // R9: exact packet needs no commit
    send(16, 16'h2000);
    wait_drain();
    chk(pkt_cnt == 1, "R9 no pulse on full packet", pkt_cnt, 1);

    // R6: buffer-full exit
    send(100, 16'h3000);
    wait_drain();
    chk(max_run == 64, "R6 read run capped by depth", max_run, 64);
    chk(pkt_cnt == 2, "R9 pulse after 36-word tail", pkt_cnt, 2);

    // R10: IN FIFO full stalls writes
    in_cap = 24; drain_en = 1'b0;
    send(40, 16'h4000);
    repeat (150) @(posedge clk);
    #3;
    chk(in_q.size() == 24, "R10 IN fill stops at limit", in_q.size(), 24);
    chk(wr_n == 1'b1, "R10 write held while full", wr_n, 1);
    drain_en = 1'b1;
    wait_drain();
    in_cap = 1000;
    chk(pkt_cnt == 3, "R9 pulse after stalled batch", pkt_cnt, 3);

    // R2: sync dropped after start has no effect
    @(posedge clk); #1 sync_in = 1'b0;
    send(5, 16'h5000);
    wait_drain();
    chk(pkt_cnt == 4, "R9 pulse after 5 words", pkt_cnt, 4);
    chk(cfg_done == 1'b1, "R1 done stays high", cfg_done, 1);

    chk(under_err == 0, "R3 read only when OUT holds data", under_err, 0);
    chk(oe_err == 0, "R3 oe_n follows rd_n", oe_err, 0);
    chk(wempty_err == 0, "R4 write only from non-empty buffer", wempty_err, 0);
    chk(over_err == 0, "R10 no write into full IN FIFO", over_err, 0);
    chk(addr_err == 0, "R7 address switched only when idle", addr_err, 0);
    chk(bus_err == 0, "R8 no bus contention", bus_err, 0);
    finish_run();
  end
endmodule